// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the hardware entry into a maskable interrupt for a small 8-bit processor core. It watches two request bits from a pending-interrupt register: an external request and a timer request. It also watches the core's interrupt-mask flag. When a request is present and the mask is clear, the block saves the core's context on a stack that grows downward, in page zero. It writes one byte per cycle through a byte-wide memory write port. It then sets the mask flag and reads a 16-bit handler address from a fixed high address. Last, it presents that address as the new program counter.

The core supplies its current program counter, index register, accumulator, condition-code byte and stack pointer. The sequencer captures these values when it starts, so later changes on those inputs do not affect the entry in progress. The external request wins over the timer request. Only the external request is consumed by the entry, through a one-cycle clear pulse. The timer request stays pending until the timer's own flags are cleared elsewhere. Every entry takes a fixed ten cycles.

Top module: `intEntry`

## Requirements
- R1: An entry starts on the clock edge after the sampling cycle, with `busy` high from the next cycle, only when `pendIn[1:0]` is nonzero and `ccIn[3]` (the mask flag) is 0. In any other case `busy` stays low and no memory access is made.
- R2: The five context writes come on the first five busy cycles, one per cycle. Each is at address `{8'h00, sp}`. They are, in order: PC low byte at SP, PC high byte at SP-1, X at SP-2, A at SP-3, CC at SP-4, where SP is the value sampled at start and the arithmetic wraps modulo 256.
- R3: The CC byte pushed is the sampled value with the mask flag still clear. `ccOut` shows that value with bit 3 set once the entry completes.
- R4: When `done` is high, `spOut` equals the sampled SP minus 5, modulo 256.
- R5: If `pendIn[0]` is 1 at start, the handler address is read as high byte from 0xFFFA and low byte from 0xFFFB, whatever `pendIn[1]` holds.
- R6: If only `pendIn[1]` is set at start, the handler address is read as high byte from 0xFFF8 and low byte from 0xFFF9.
- R7: `clrExt` pulses for one cycle, together with `done`, only on entries that service the external request. It never pulses on a timer-only entry.
- R8: `busy` stays high for exactly 10 cycles per entry. `done` is a single-cycle pulse in the tenth busy cycle, and `pcOut` then holds {byte at high address, byte at low address}. Read data is returned on `memRdData` during the cycle after `memRdEn`.
- R9: Changes on `pendIn`, `pcIn`, `xIn`, `aIn`, `ccIn` and `spIn` while `busy` is high do not alter the writes, the vector chosen or the final outputs of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendIn | input | 2 | Pending requests: bit 0 external, bit 1 timer |
| pcIn | input | 16 | Current program counter |
| xIn | input | 8 | Current index register |
| aIn | input | 8 | Current accumulator |
| ccIn | input | 8 | Current condition codes, bit 3 is the mask flag |
| spIn | input | 8 | Current stack pointer (low byte, page zero) |
| memRdData | input | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse when the new PC is presented |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 16 | Memory address |
| memWrData | output | 8 | Memory write data |
| pcOut | output | 16 | Handler address loaded into the PC |
| ccOut | output | 8 | Condition codes with the mask flag set |
| spOut | output | 8 | Stack pointer after the pushes |
| clrExt | output | 1 | Pulse clearing the external pending bit |

## Verification
The timing is counted from the edge that samples a request. The five stack writes fall in busy cycles 1 to 5, the mask is set in cycle 6, and the vector reads are issued in cycles 7 and 8. `pcOut`, `done` and `clrExt` are due in cycle 10, and `busy` must be low again in cycle 11. The bench applies inputs just after a falling edge and samples at every later falling edge. It indexes each observation by the number of edges since the inputs were applied. It compares that observation against the slot computed for that cycle, so a write or pulse that arrives one cycle early or late is reported as a failure.

// File: rtl/intEntryPkg.sv
package intEntryPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PCL, ST_PCH, ST_X, ST_A, ST_CC,
    ST_MASK, ST_RDHI, ST_RDLO, ST_CAPLO, ST_LOAD
  } entryState_t;

  typedef enum logic [2:0] {
    SEL_PCL, SEL_PCH, SEL_X, SEL_A, SEL_CC
  } pushSel_t;

  typedef struct packed {
    logic     latch;
    logic     push;
    pushSel_t sel;
    logic     setMask;
    logic     rdVec;
    logic     rdLo;
    logic     capHi;
    logic     capLo;
    logic     done;
  } strobe_t;

endpackage

// File: rtl/intEntryCtrl.sv
module intEntryCtrl
  import intEntryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pendIn,
  input  logic       maskFlag,
  output strobe_t    stb,
  output logic       busy
);

  entryState_t state, nextState;
  logic        start;

  assign start = (|pendIn) && !maskFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (start) nextState = ST_PCL;
      ST_PCL:   nextState = ST_PCH;
      ST_PCH:   nextState = ST_X;
      ST_X:     nextState = ST_A;
      ST_A:     nextState = ST_CC;
      ST_CC:    nextState = ST_MASK;
      ST_MASK:  nextState = ST_RDHI;
      ST_RDHI:  nextState = ST_RDLO;
      ST_RDLO:  nextState = ST_CAPLO;
      ST_CAPLO: nextState = ST_LOAD;
      ST_LOAD:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.sel = SEL_PCL;
    unique case (state)
      ST_IDLE:  stb.latch = start;
      ST_PCL:   begin stb.push = 1'b1; stb.sel = SEL_PCL; end
      ST_PCH:   begin stb.push = 1'b1; stb.sel = SEL_PCH; end
      ST_X:     begin stb.push = 1'b1; stb.sel = SEL_X;   end
      ST_A:     begin stb.push = 1'b1; stb.sel = SEL_A;   end
      ST_CC:    begin stb.push = 1'b1; stb.sel = SEL_CC;  end
      ST_MASK:  stb.setMask = 1'b1;
      ST_RDHI:  stb.rdVec = 1'b1;
      ST_RDLO:  begin stb.rdVec = 1'b1; stb.rdLo = 1'b1; stb.capHi = 1'b1; end
      ST_CAPLO: stb.capLo = 1'b1;
      ST_LOAD:  stb.done = 1'b1;
      default:  stb = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MASK_BIT = 3,
  parameter logic [DATA_W-1:0] STACK_PAGE = '0,
  parameter logic [2*DATA_W-1:0] VEC_EXT = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] VEC_TMR = 16'hFFF8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                extReq,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   xIn,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   ccIn,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   ccOut,
  output logic [DATA_W-1:0]   spOut,
  output logic                clrExt
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcR, vecBase;
  logic [DATA_W-1:0] xR, aR, ccR, spR, vecHi;
  logic              srcExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR <= '0; xR <= '0; aR <= '0; ccR <= '0; spR <= '0;
      srcExt <= 1'b0; vecHi <= '0; pcOut <= '0;
    end else begin
      if (stb.latch) begin
        pcR <= pcIn; xR <= xIn; aR <= aIn; ccR <= ccIn; spR <= spIn;
        srcExt <= extReq;
      end
      if (stb.push)    spR <= spR - 1'b1;
      if (stb.setMask) ccR[MASK_BIT] <= 1'b1;
      if (stb.capHi)   vecHi <= memRdData;
      if (stb.capLo)   pcOut <= {vecHi, memRdData};
    end
  end

  assign vecBase = srcExt ? VEC_EXT : VEC_TMR;

  always_comb begin
    unique case (stb.sel)
      SEL_PCL: memWrData = pcR[DATA_W-1:0];
      SEL_PCH: memWrData = pcR[ADDR_W-1:DATA_W];
      SEL_X:   memWrData = xR;
      SEL_A:   memWrData = aR;
      SEL_CC:  memWrData = ccR;
      default: memWrData = '0;
    endcase
  end

  always_comb begin
    if (stb.push)       memAddr = {STACK_PAGE, spR};
    else if (stb.rdVec) memAddr = vecBase + {{(ADDR_W-1){1'b0}}, stb.rdLo};
    else                memAddr = '0;
  end

  assign ccOut  = ccR;
  assign spOut  = spR;
  assign clrExt = stb.done & srcExt;

endmodule

// File: rtl/intEntry.sv
module intEntry
  import intEntryPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MASK_BIT = 3,
  parameter logic [DATA_W-1:0] STACK_PAGE = '0,
  parameter logic [2*DATA_W-1:0] VEC_EXT = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] VEC_TMR = 16'hFFF8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          pendIn,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   xIn,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   ccIn,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                busy,
  output logic                done,
  output logic                memWrEn,
  output logic                memRdEn,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   ccOut,
  output logic [DATA_W-1:0]   spOut,
  output logic                clrExt
);

  strobe_t stb;

  intEntryCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .maskFlag(ccIn[MASK_BIT]),
    .stb(stb), .busy(busy)
  );

  intEntryPath #(
    .DATA_W(DATA_W), .MASK_BIT(MASK_BIT), .STACK_PAGE(STACK_PAGE),
    .VEC_EXT(VEC_EXT), .VEC_TMR(VEC_TMR)
  ) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .extReq(pendIn[0]),
    .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .ccIn(ccIn), .spIn(spIn),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .pcOut(pcOut), .ccOut(ccOut), .spOut(spOut), .clrExt(clrExt)
  );

  assign memWrEn = stb.push;
  assign memRdEn = stb.rdVec;
  assign done    = stb.done;

endmodule

// File: rtl/intEntryChk.sv
module intEntryChk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  pendIn,
  input logic [7:0]  ccIn,
  input logic        busy,
  input logic        done,
  input logic        memWrEn,
  input logic        memRdEn,
  input logic [15:0] memAddr,
  input logic        clrExt
);

  logic [3:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (pendIn != 2'b00) && !ccIn[3]) |=> busy);

  p_no_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ((pendIn == 2'b00) || ccIn[3])) |=> !busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWrEn && !memRdEn));

  p_stack_page_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr[15:8] == 8'h00 && !memRdEn));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr[7:0] == $past(memAddr[7:0]) - 8'd1));

  p_vec_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr[15:2] == 14'h3FFE));

  p_clr_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrExt |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_ten_cycles_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && busyCnt == 4'd9));

  p_busy_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyCnt == 4'd9) |-> done);

endmodule

bind intEntry intEntryChk i_chk (
  .clk(clk), .rstN(rstN), .pendIn(pendIn), .ccIn(ccIn), .busy(busy),
  .done(done), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
  .clrExt(clrExt)
);

// File: tb/test_intEntry.sv
module test_intEntry;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pendIn = '0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIn = '0, aIn = '0, ccIn = 8'h08, spIn = '0;
  logic [7:0]  memRdData = '0;
  logic        busy, done, memWrEn, memRdEn, clrExt;
  logic [15:0] memAddr, pcOut;
  logic [7:0]  memWrData, ccOut, spOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] vec [4];
  logic [7:0] rdPend = 8'hEE;

  always #2.5 clk = ~clk;

  intEntry i_intEntry (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .pcIn(pcIn), .xIn(xIn),
    .aIn(aIn), .ccIn(ccIn), .spIn(spIn), .memRdData(memRdData),
    .busy(busy), .done(done), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memAddr(memAddr), .memWrData(memWrData), .pcOut(pcOut),
    .ccOut(ccOut), .spOut(spOut), .clrExt(clrExt)
  );

  // memory model: data for a read request appears in the following cycle
  always @(negedge clk) begin
    memRdData <= rdPend;
    rdPend <= (memRdEn && memAddr[15:2] == 14'h3FFE) ? vec[memAddr[1:0]] : 8'hEE;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expVector(input logic [1:0] p);
    return p[0] ? {vec[2], vec[3]} : {vec[0], vec[1]};
  endfunction

  // one serviced entry; glitch changes inputs mid-sequence (R9)
  task automatic runEntry(input logic [1:0] p, input logic [15:0] pc, input logic [7:0] x,
                          input logic [7:0] a, input logic [7:0] cc, input logic [7:0] sp,
                          input bit glitch);
    logic [15:0] wAddr [5];
    logic [7:0]  wData [5];
    logic [7:0]  expData [5];
    int nWr = 0, busyCnt = 0, doneCnt = 0, doneAt = 0, clrCnt = 0, lateBusy = 0;
    logic [15:0] pcSeen = '0;
    logic [7:0]  ccSeen = '0, spSeen = '0;
    for (int i = 0; i < 4; i++) vec[i] = 8'($urandom);
    pendIn = p; pcIn = pc; xIn = x; aIn = a; ccIn = cc & 8'hF7; spIn = sp;
    expData[0] = pc[7:0]; expData[1] = pc[15:8]; expData[2] = x;
    expData[3] = a; expData[4] = cc & 8'hF7;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 1) chk(busy == 1'b1, "R1 start", 32'(busy), 32'd1);
      if (busy && k <= 10) busyCnt++;
      if (busy && k > 10) lateBusy++;
      if (memWrEn) begin
        if (nWr < 5) begin wAddr[nWr] = memAddr; wData[nWr] = memWrData; end
        if (k != nWr + 1) chk(1'b0, "R2 write slot", 32'(k), 32'(nWr + 1));
        nWr++;
      end
      if (done) begin
        doneCnt++; doneAt = k;
        pcSeen = pcOut; ccSeen = ccOut; spSeen = spOut;
        ccIn = ccIn | 8'h08;
      end
      if (clrExt) clrCnt++;
      if (glitch && k == 3) begin
        pendIn = 2'($urandom); pcIn = 16'($urandom); xIn = 8'($urandom);
        aIn = 8'($urandom); ccIn = 8'($urandom) & 8'hF7; spIn = 8'($urandom);
      end
    end
    chk(nWr == 5, "R2 write count", 32'(nWr), 32'd5);
    for (int j = 0; j < 5 && j < nWr; j++) begin
      chk(wAddr[j] == {8'h00, 8'(sp - 8'(j))}, "R2 push address", 32'(wAddr[j]), 32'({8'h00, 8'(sp - 8'(j))}));
      chk(wData[j] == expData[j], glitch ? "R9 push data" : "R2 push data", 32'(wData[j]), 32'(expData[j]));
    end
    chk(busyCnt == 10 && lateBusy == 0, "R8 busy length", 32'(busyCnt + lateBusy), 32'd10);
    chk(doneCnt == 1 && doneAt == 10, "R8 done slot", 32'(doneAt), 32'd10);
    chk(pcSeen == expVector(p), p[0] ? "R5 external vector" : "R6 timer vector", 32'(pcSeen), 32'(expVector(p)));
    chk(ccSeen == (cc | 8'h08), "R3 mask set", 32'(ccSeen), 32'(cc | 8'h08));
    chk(spSeen == 8'(sp - 8'd5), "R4 final sp", 32'(spSeen), 32'(8'(sp - 8'd5)));
    chk(clrCnt == (p[0] ? 1 : 0), "R7 clear pulse", 32'(clrCnt), p[0] ? 32'd1 : 32'd0);
    pendIn = '0;
  endtask

  task automatic noEntry(input logic [1:0] p, input logic [7:0] cc);
    int seen = 0;
    pendIn = p; ccIn = cc;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (busy || memWrEn || memRdEn) seen++;
    end
    chk(seen == 0, "R1 no entry", 32'(seen), 32'd0);
    pendIn = '0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && memWrEn == 0 && memRdEn == 0, "R1 reset state",
        {28'd0, busy, done, memWrEn, memRdEn}, 32'd0);
    // directed corners
    runEntry(2'b01, 16'h1234, 8'h56, 8'h78, 8'h00, 8'hFF, 1'b0);  // R5 external alone
    runEntry(2'b10, 16'hBEEF, 8'h11, 8'h22, 8'h01, 8'h80, 1'b0);  // R6 timer alone
    runEntry(2'b11, 16'hCAFE, 8'h33, 8'h44, 8'hF7, 8'h02, 1'b0);  // R5 both, sp wraps (R4)
    runEntry(2'b10, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h03, 1'b1);  // R9 glitch on timer entry
    noEntry(2'b00, 8'h00);   // R1 nothing pending
    noEntry(2'b11, 8'h08);   // R1 masked
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] p;
      p = 2'($urandom);
      if (p == 2'b00) noEntry(p, 8'($urandom));
      else runEntry(p, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), ($urandom % 3) == 0);
      @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule